// File: doc/BRIEF.md
# Differential Channel Burst-Averaging Acquisition Sequencer

This block performs one complete measurement sweep across a set of differential analog inputs. It starts on a single-cycle start strobe. It first emits a one-cycle command that reconfigures the analog switch matrix into the measurement position. It then holds off for a fixed settling interval so the switches can settle. After that it drives an external converter through a request / busy / done handshake.

Each channel is converted a fixed number of times back to back, and the readings are summed in a wide accumulator. The truncated mean of the readings is written into a per-channel result register. Channels are visited from the lowest index upward. After the last channel's result is stored, a one-cycle completion flag is raised. Software or downstream logic reads the results through an asynchronous read port, addressed by channel index.

The defaults describe 16 channels, 8 readings per channel, 16-bit samples and a 40-cycle settling wait. That wait is 1 µs at a 40 MHz clock.

Top module: `diffscan_avg_seq`

## Requirements
- R1: After reset every result register reads 0, and `done_o`, `sw_cfg_o` and `conv_req_o` are low.
- R2: A `start_i` pulse sampled while the block is idle produces exactly one `sw_cfg_o` pulse, high for one cycle, in the cycle right after the sampling edge. `sw_cfg_o` never rises otherwise.
- R3: No conversion is requested until `SETTLE_CYC` (40) full cycles have passed after the `sw_cfg_o` cycle. The first `conv_req_o` appears exactly `SETTLE_CYC`+1 cycles after the `sw_cfg_o` cycle.
- R4: `conv_req_o` is a one-cycle request. It is never raised while `adc_busy_i` is high, and never raised again before `adc_done_i` has returned the previous reading.
- R5: Each sweep issues exactly `BURST` (8) requests per channel, which is 128 in total. `adc_ch_o` carries the channel index of every request, stepping 0, 1, ... 15 in ascending order.
- R6: A channel's result equals the sum of its 8 readings shifted right by 3 bits. The sum is held in a 19-bit accumulator with no wrap, so 8 readings of 0xFFFF give 0xFFFF.
- R7: The mean is truncated rather than rounded. For example, readings summing to 8·c+7 give the result c.
- R8: `rd_data_o` shows the register selected by `rd_addr_i` combinationally. A channel's register keeps its previous value until that channel's own burst of readings is finished.
- R9: `done_o` is high for exactly one cycle, in the cycle after the last channel's result is written. In that cycle all results of the sweep are readable.
- R10: A `start_i` pulse arriving while a sweep is running is ignored. This includes a pulse in the same cycle as `done_o`. A pulse arriving once the block is idle again starts a new sweep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Sweep start strobe |
| sw_cfg_o | output | 1 | One-cycle switch-matrix reconfiguration command |
| conv_req_o | output | 1 | Conversion request to the converter |
| adc_ch_o | output | CH_W (4) | Channel index of the current conversion |
| adc_busy_i | input | 1 | Converter busy |
| adc_done_i | input | 1 | Converter reading valid, one cycle |
| adc_data_i | input | SAMPLE_W (16) | Converter reading |
| rd_addr_i | input | CH_W (4) | Result read address |
| rd_data_o | output | SAMPLE_W (16) | Result read data |
| done_o | output | 1 | Sweep complete, one cycle |

## Verification
The completion flag and a new start strobe can fall into the same cycle. Because the block is then still leaving its last state, that strobe must be dropped. The bench raises `start_i` exactly in the `done_o` cycle. It then confirms at the ports that no reconfiguration command and no conversion request follows for 60 cycles. A strobe given afterwards must launch a normal sweep. The bench also keeps the converter's busy line high for two cycles after some readings, so that a pending request and a busy converter meet in the same cycle; the request must wait.

// File: rtl/diffscan_pkg.sv
`timescale 1ns/1ps
package diffscan_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SWITCH,
    ST_SETTLE,
    ST_REQ,
    ST_WAIT,
    ST_WRITE,
    ST_FIN
  } scan_state_e;

  // true when n is a non-zero power of two
  function automatic bit is_pow2(input int n);
    return (n > 0) && ((n & (n - 1)) == 0);
  endfunction

endpackage

// File: rtl/diffscan_ctrl.sv
`timescale 1ns/1ps
module diffscan_ctrl
  import diffscan_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int SETTLE_CYC = 40,
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int SET_W     = $clog2(SETTLE_CYC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            adc_busy_i,
  input  logic            adc_done_i,
  input  logic            burst_last_i,
  output logic            sw_cfg_o,
  output logic            conv_req_o,
  output logic [CH_W-1:0] adc_ch_o,
  output logic            sample_take_o,
  output logic            wr_en_o,
  output logic [CH_W-1:0] wr_addr_o,
  output logic            done_o
);

  localparam logic [CH_W-1:0]  LAST_CH    = CH_W'(NUM_CH - 1);
  localparam logic [SET_W-1:0] SETTLE_END = SET_W'(SETTLE_CYC - 1);

  scan_state_e      state_q, state_d;
  logic [SET_W-1:0] settle_q;
  logic [CH_W-1:0]  ch_q;

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_SWITCH;
      ST_SWITCH: state_d = ST_SETTLE;
      ST_SETTLE: if (settle_q == SETTLE_END) state_d = ST_REQ;
      ST_REQ:    if (!adc_busy_i) state_d = ST_WAIT;
      ST_WAIT:   if (adc_done_i) state_d = burst_last_i ? ST_WRITE : ST_REQ;
      ST_WRITE:  state_d = (ch_q == LAST_CH) ? ST_FIN : ST_REQ;
      ST_FIN:    state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      settle_q <= '0;
      ch_q     <= '0;
    end else begin
      state_q  <= state_d;
      settle_q <= (state_q == ST_SETTLE) ? settle_q + 1'b1 : '0;
      if (state_q == ST_SWITCH)
        ch_q <= '0;
      else if (state_q == ST_WRITE && ch_q != LAST_CH)
        ch_q <= ch_q + 1'b1;
    end
  end

  // named events for the neighbours and the checks
  assign sw_cfg_o      = (state_q == ST_SWITCH);
  assign conv_req_o    = (state_q == ST_REQ) && !adc_busy_i;
  assign adc_ch_o      = ch_q;
  assign sample_take_o = (state_q == ST_WAIT) && adc_done_i;
  assign wr_en_o       = (state_q == ST_WRITE);
  assign wr_addr_o     = ch_q;
  assign done_o        = (state_q == ST_FIN);

  // ---------------- checks ----------------
  logic [SET_W:0] since_sw_q;
  logic           pending_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_sw_q <= '0;
      pending_q  <= 1'b0;
    end else begin
      if (sw_cfg_o)
        since_sw_q <= '0;
      else if (since_sw_q < (SET_W+1)'(SETTLE_CYC))
        since_sw_q <= since_sw_q + 1'b1;
      if (conv_req_o)
        pending_q <= 1'b1;
      else if (adc_done_i)
        pending_q <= 1'b0;
    end
  end

  // R3
  settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req_o |-> since_sw_q >= (SET_W+1)'(SETTLE_CYC));

  // R4
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req_o |-> !pending_q && !adc_busy_i);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(wr_en_o) && ($past(wr_addr_o) == LAST_CH));

  // R2
  sw_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_cfg_o |-> $past(start_i) && !$past(sw_cfg_o));

endmodule

// File: rtl/diffscan_accum.sv
`timescale 1ns/1ps
module diffscan_accum #(
  parameter int SAMPLE_W = 16,
  parameter int BURST    = 8,
  localparam int SHIFT   = $clog2(BURST),
  localparam int ACC_W   = SAMPLE_W + SHIFT,
  localparam int CNT_W   = (SHIFT > 0) ? SHIFT : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_take_i,
  input  logic                clear_i,
  input  logic [SAMPLE_W-1:0] data_i,
  output logic                burst_last_o,
  output logic [SAMPLE_W-1:0] mean_o
);

  // truncated mean: drop the low SHIFT bits of the burst sum
  function automatic logic [SAMPLE_W-1:0] burst_mean(input logic [ACC_W-1:0] sum);
    return sum[ACC_W-1 -: SAMPLE_W];
  endfunction

  logic [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (sample_take_i) begin
      acc_q <= acc_q + ACC_W'(data_i);
      cnt_q <= (BURST > 1) ? cnt_q + 1'b1 : '0;
    end
  end

  assign burst_last_o = (cnt_q == CNT_W'(BURST - 1));
  assign mean_o       = burst_mean(acc_q);

  // ---------------- checks ----------------
  logic [SHIFT:0] taken_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      taken_q <= '0;
    else if (clear_i)
      taken_q <= '0;
    else if (sample_take_i)
      taken_q <= taken_q + 1'b1;
  end

  initial begin
    burst_pow2_chk: assert (diffscan_pkg::is_pow2(BURST));
  end

  // R5
  write_full_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |-> taken_q == (SHIFT+1)'(BURST));

  // R6
  acc_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_take_i |-> ((({1'b0, acc_q} + (ACC_W+1)'(data_i)) >> ACC_W) == '0));

endmodule

// File: rtl/diffscan_regfile.sv
`timescale 1ns/1ps
module diffscan_regfile #(
  parameter int NUM_CH   = 16,
  parameter int SAMPLE_W = 16,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en_i,
  input  logic [CH_W-1:0]     wr_addr_i,
  input  logic [SAMPLE_W-1:0] wr_data_i,
  input  logic [CH_W-1:0]     rd_addr_i,
  output logic [SAMPLE_W-1:0] rd_data_o
);

  logic [SAMPLE_W-1:0] entry_q [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        entry_q[g] <= '0;
      else if (wr_en_i && wr_addr_i == CH_W'(g))
        entry_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = (int'(rd_addr_i) < NUM_CH) ? entry_q[rd_addr_i] : '0;

  // ---------------- checks ----------------
  logic [CH_W-1:0] last_wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      last_wr_q <= '0;
    else if (wr_en_i)
      last_wr_q <= wr_addr_i;
  end

  // R5
  wr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i != '0) |-> last_wr_q == wr_addr_i - 1'b1);

endmodule

// File: rtl/diffscan_avg_seq.sv
`timescale 1ns/1ps
module diffscan_avg_seq #(
  parameter int NUM_CH     = 16,
  parameter int BURST      = 8,
  parameter int SAMPLE_W   = 16,
  parameter int SETTLE_CYC = 40,
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  output logic                sw_cfg_o,
  output logic                conv_req_o,
  output logic [CH_W-1:0]     adc_ch_o,
  input  logic                adc_busy_i,
  input  logic                adc_done_i,
  input  logic [SAMPLE_W-1:0] adc_data_i,
  input  logic [CH_W-1:0]     rd_addr_i,
  output logic [SAMPLE_W-1:0] rd_data_o,
  output logic                done_o
);

  logic                sample_take;
  logic                burst_last;
  logic                wr_en;
  logic [CH_W-1:0]     wr_addr;
  logic [SAMPLE_W-1:0] mean;

  diffscan_ctrl #(
    .NUM_CH    (NUM_CH),
    .SETTLE_CYC(SETTLE_CYC)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .adc_busy_i   (adc_busy_i),
    .adc_done_i   (adc_done_i),
    .burst_last_i (burst_last),
    .sw_cfg_o     (sw_cfg_o),
    .conv_req_o   (conv_req_o),
    .adc_ch_o     (adc_ch_o),
    .sample_take_o(sample_take),
    .wr_en_o      (wr_en),
    .wr_addr_o    (wr_addr),
    .done_o       (done_o)
  );

  diffscan_accum #(
    .SAMPLE_W(SAMPLE_W),
    .BURST   (BURST)
  ) u_accum (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_take_i(sample_take),
    .clear_i      (wr_en),
    .data_i       (adc_data_i),
    .burst_last_o (burst_last),
    .mean_o       (mean)
  );

  diffscan_regfile #(
    .NUM_CH  (NUM_CH),
    .SAMPLE_W(SAMPLE_W)
  ) u_regfile (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(mean),
    .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o)
  );

endmodule

// File: tb/test_diffscan_avg_seq.sv
`timescale 1ns/1ps
module test_diffscan_avg_seq;

  localparam int NCH    = 16;
  localparam int NB     = 8;
  localparam int SETTLE = 40;
  localparam int LAT    = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        sw_cfg_o, conv_req_o, done_o;
  logic [3:0]  adc_ch_o;
  logic        adc_busy, adc_done;
  logic [15:0] adc_data;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data_o;

  always #5 clk = ~clk;

  diffscan_avg_seq i_diffscan_avg_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .sw_cfg_o(sw_cfg_o), .conv_req_o(conv_req_o), .adc_ch_o(adc_ch_o),
    .adc_busy_i(adc_busy), .adc_done_i(adc_done), .adc_data_i(adc_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data_o), .done_o(done_o)
  );

  int n_chk = 0, n_bad = 0;
  int adc_mode = 0;

  function automatic logic [15:0] pat(int m, int ch, int k);
    case (m)
      0: return 16'(ch * 1000 + k * 37 + 5);
      1: return 16'hFFFF;
      2: return (k == 0) ? 16'(ch * 8 + 7) : 16'h0;
      default: return 16'((ch * 40503 + k * 9973 + 12345) & 32'hFFFF);
    endcase
  endfunction

  // behavioural converter
  logic       conv_on;
  int         lat_cnt, tail, nconv;
  logic [3:0] rch;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adc_busy <= 0; adc_done <= 0; adc_data <= 0;
      conv_on <= 0; lat_cnt <= 0; tail <= 0; nconv <= 0; rch <= 0;
    end else begin
      adc_done <= 0;
      if (sw_cfg_o) nconv <= 0;
      if (conv_req_o && !adc_busy) begin
        adc_busy <= 1; conv_on <= 1; lat_cnt <= LAT; rch <= adc_ch_o;
      end else if (conv_on) begin
        if (lat_cnt == 0) begin
          conv_on <= 0; adc_done <= 1;
          adc_data <= pat(adc_mode, int'(rch), nconv % NB);
          nconv <= nconv + 1;
          if (adc_mode == 3) tail <= 2; else adc_busy <= 0;
        end else lat_cnt <= lat_cnt - 1;
      end else if (tail != 0) begin
        tail <= tail - 1;
        if (tail == 1) adc_busy <= 0;
      end
    end
  end

  // monitor
  int cyc = 0;
  logic start_at_edge = 0;
  always @(posedge clk) begin cyc <= cyc + 1; start_at_edge <= start; end

  int sw_cnt = 0, sw_err = 0, sw_cyc = 0, gap = 0, req_cnt = 0, busy_err = 0;
  int order_err = 0, issued = 0, done_cnt = 0, done_err = 0;
  bit first_pending = 0, done_prev = 0;
  always @(negedge clk) if (rst_n) begin
    if (sw_cfg_o) begin
      sw_cnt++; sw_cyc = cyc; first_pending = 1; issued = 0;
      if (!start_at_edge) sw_err++;
    end
    if (conv_req_o) begin
      req_cnt++;
      if (adc_busy) busy_err++;
      if (first_pending) begin gap = cyc - sw_cyc; first_pending = 0; end
      if (int'(adc_ch_o) != issued / NB) order_err++;
      issued++;
    end
    if (done_o) begin done_cnt++; if (done_prev) done_err++; end
    done_prev = done_o;
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  int prev_res [NCH];
  int exp_res  [NCH];

  task automatic t_reset();
    int bad = 0;
    for (int c = 0; c < NCH; c++) begin
      rd_addr = 4'(c); #0.2;
      if (rd_data_o != 0) bad++;
    end
    check(bad == 0, "R1 results zero", bad, 0);
    check(!done_o && !sw_cfg_o && !conv_req_o, "R1 outputs idle",
          int'({done_o, sw_cfg_o, conv_req_o}), 0);
    for (int c = 0; c < NCH; c++) prev_res[c] = 0;
  endtask

  // one full sweep with pattern m; poke_mid strobes start mid-sweep,
  // on_done strobes start in the done cycle
  task automatic t_sweep(int m, string tag, bit poke_mid, bit on_done);
    int sw0, req0, dn0, sum;
    adc_mode = m;
    for (int c = 0; c < NCH; c++) begin
      sum = 0;
      for (int k = 0; k < NB; k++) sum += int'(pat(m, c, k));
      exp_res[c] = sum >> 3;
    end
    sw0 = sw_cnt; req0 = req_cnt; dn0 = done_cnt;
    busy_err = 0; order_err = 0; sw_err = 0;
    pulse_start();
    if (poke_mid) begin
      while (adc_ch_o != 4'd3) @(negedge clk);
      pulse_start();
    end
    while (adc_ch_o != 4'd6) @(negedge clk);
    rd_addr = 4'd6; #0.2;
    check(int'(rd_data_o) == prev_res[6], {tag, " R8 ch6 keeps old value"},
          int'(rd_data_o), prev_res[6]);
    rd_addr = 4'd5; #0.2;
    check(int'(rd_data_o) == exp_res[5], {tag, " R8 ch5 updated"},
          int'(rd_data_o), exp_res[5]);
    while (!done_o) @(negedge clk);
    if (on_done) start = 1;
    for (int c = 0; c < NCH; c++) begin
      rd_addr = 4'(c); #0.2;
      check(int'(rd_data_o) == exp_res[c], {tag, " R6 R9 result"},
            int'(rd_data_o), exp_res[c]);
    end
    @(negedge clk);
    start = 0;
    check(!done_o && done_cnt - dn0 == 1 && done_err == 0, {tag, " R9 done one cycle"},
          done_cnt - dn0, 1);
    check(sw_cnt - sw0 == 1 && sw_err == 0, {tag, " R2 R10 one switch command"},
          sw_cnt - sw0, 1);
    check(gap == SETTLE + 1, {tag, " R3 settle gap"}, gap, SETTLE + 1);
    check(busy_err == 0, {tag, " R4 no request while busy"}, busy_err, 0);
    check(order_err == 0 && req_cnt - req0 == NCH * NB, {tag, " R5 request order/count"},
          req_cnt - req0, NCH * NB);
    for (int c = 0; c < NCH; c++) prev_res[c] = exp_res[c];
    if (on_done) begin
      sw0 = sw_cnt; req0 = req_cnt;
      repeat (60) @(negedge clk);
      check(sw_cnt == sw0 && req_cnt == req0, "R10 start on done ignored",
            sw_cnt - sw0 + req_cnt - req0, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_sweep(0, "ramp",  1'b0, 1'b0);
    t_sweep(1, "max",   1'b0, 1'b0);   // R6 no wrap
    t_sweep(2, "trunc", 1'b0, 1'b0);   // R7 truncation
    t_sweep(3, "busytail", 1'b1, 1'b0); // R4, R10 mid-sweep start
    t_sweep(0, "ramp2", 1'b0, 1'b1);   // R10 start in done cycle
    t_sweep(1, "after", 1'b0, 1'b0);   // R10 later start accepted
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule